// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the control state machine for a datapath that runs each instruction over several clock cycles. A single ALU and a shared memory port are reused across those cycles. The sequencer reads the 6-bit opcode held in the instruction register and the ALU zero flag. It produces the select and enable lines that steer the datapath on each cycle.

Every instruction starts with the same two cycles:

- **Fetch:** the instruction is loaded and PC+4 is formed.
- **Decode:** the operands are read and the branch target is precomputed.

After decode, the state path splits by instruction class:

- Branch and jump take 3 cycles in total.
- Register-format and store take 4 cycles.
- Load takes 5 cycles.

All control pins are plain levels with no handshake. The block carries no data stream, so no valid/ready interface applies.

All datapath controls are Moore outputs decoded from the state register. The one exception is `pc_load`, the effective PC enable. It combines the unconditional PC write with the branch-conditional write gated by `zero` in the same cycle.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle presents the fetch controls. A reset asserted in the middle of an instruction abandons it.
- R2: The fetch cycle drives the following:
  - `mem_rd`, `ir_wr` and `pc_wr` all set to 1.
  - `alu_a_sel`=0 (PC).
  - `alu_b_sel`=2'b01 (constant 4).
  - `alu_op`=2'b00 (add).
  - `pc_src`=2'b00.
  - All other enables 0.
- R3: The decode cycle always follows fetch. It drives `alu_a_sel`=0, `alu_b_sel`=2'b11 (shifted offset) and `alu_op`=2'b00, with every write enable 0.
- R4: Opcode 6'h00 (register-format) takes 4 cycles. Cycle 3 drives `alu_a_sel`=1, `alu_b_sel`=2'b00 and `alu_op`=2'b10 (function field). Cycle 4 drives `rf_wr`=1, `rf_dst`=1 and `rf_from_mem`=0.
- R5: Opcode 6'h23 (load) takes 5 cycles:
  - Cycle 3 drives `alu_a_sel`=1, `alu_b_sel`=2'b10 (sign-extended offset) and `alu_op`=2'b00.
  - Cycle 4 drives `mem_rd`=1 only.
  - Cycle 5 drives `rf_wr`=1, `rf_dst`=0 and `rf_from_mem`=1.
- R6: Opcode 6'h2B (store) takes 4 cycles. Cycle 3 forms the address exactly as in R5. Cycle 4 drives `mem_wr`=1 only.
- R7: Opcode 6'h04 (branch-if-equal) takes 3 cycles. Cycle 3 drives `br_wr`=1, `alu_a_sel`=1, `alu_b_sel`=2'b00, `alu_op`=2'b01 (subtract) and `pc_src`=2'b01.
- R8: Opcode 6'h02 (jump) takes 3 cycles. Cycle 3 drives `pc_wr`=1 and `pc_src`=2'b10, with all other enables 0.
- R9: Any other opcode returns to fetch directly after decode. It asserts no register, memory, IR or PC write in the decode cycle.
- R10: `pc_load` equals 1 when `pc_wr` is 1. It also equals 1 when `br_wr` and `zero` are both 1. In every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| br_wr | output | 1 | PC write conditioned on zero |
| ir_wr | output | 1 | Instruction register load |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| rf_wr | output | 1 | Register file write enable |
| rf_dst | output | 1 | Destination select: 1 = rd, 0 = rt |
| rf_from_mem | output | 1 | Write data select: 1 = memory data, 0 = ALU-out |
| alu_a_sel | output | 1 | ALU A: 0 = PC, 1 = A register |
| alu_b_sel | output | 2 | ALU B: 00 = B register, 01 = 4, 10 = sign-extended offset, 11 = shifted offset |
| alu_op | output | 2 | 00 = add, 01 = subtract, 10 = function field |
| pc_src | output | 2 | 00 = ALU result, 01 = ALU-out, 10 = jump target |
| pc_load | output | 1 | Effective PC enable |

## Verification
All controls except `pc_load` come from the state register. They are therefore due in the cycle after the rising edge that enters a state. For example, decode controls appear exactly one edge after fetch, and the completion cycle of a load appears four edges after its fetch. The bench samples once per cycle at the falling edge and walks each instruction class cycle by cycle against the expected control word. It then checks that fetch reappears on the cycle right after the class's last cycle, which fixes each class's length. `pc_load` is combinational from `zero`, so it is checked in the same falling-edge sample in which `zero` was driven. That check is made with both values of `zero` during the branch cycle.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_REXE   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BEQ    = 4'd8,
    ST_JMP    = 4'd9
  } mc_state_e;

  typedef struct packed {
    logic       pc_wr;
    logic       br_wr;
    logic       ir_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       rf_wr;
    logic       rf_dst;
    logic       rf_from_mem;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } mc_ctrl_t;

  localparam logic       ASEL_PC   = 1'b0;
  localparam logic       ASEL_REG  = 1'b1;
  localparam logic [1:0] BSEL_REG  = 2'b00;
  localparam logic [1:0] BSEL_FOUR = 2'b01;
  localparam logic [1:0] BSEL_SEXT = 2'b10;
  localparam logic [1:0] BSEL_SHFT = 2'b11;
  localparam logic [1:0] OP_ADD    = 2'b00;
  localparam logic [1:0] OP_SUB    = 2'b01;
  localparam logic [1:0] OP_FUNCT  = 2'b10;
  localparam logic [1:0] SRC_ALU   = 2'b00;
  localparam logic [1:0] SRC_OUT   = 2'b01;
  localparam logic [1:0] SRC_JUMP  = 2'b10;

endpackage

// File: rtl/mcseq_next_state.sv
module mcseq_next_state
  import mcseq_pkg::*;
#(
  parameter int                OPC_W  = 6,
  parameter logic [OPC_W-1:0]  OPC_R  = 6'h00,
  parameter logic [OPC_W-1:0]  OPC_LD = 6'h23,
  parameter logic [OPC_W-1:0]  OPC_ST = 6'h2B,
  parameter logic [OPC_W-1:0]  OPC_BR = 6'h04,
  parameter logic [OPC_W-1:0]  OPC_JP = 6'h02
) (
  input  mc_state_e        cur,
  input  logic [OPC_W-1:0] opcode,
  output mc_state_e        nxt
);

  logic is_r, is_ld, is_st, is_br, is_jp;

  always_comb begin
    is_r  = (opcode == OPC_R);
    is_ld = (opcode == OPC_LD);
    is_st = (opcode == OPC_ST);
    is_br = (opcode == OPC_BR);
    is_jp = (opcode == OPC_JP);
  end

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (is_ld || is_st) nxt = ST_ADDR;
        else if (is_r)      nxt = ST_REXE;
        else if (is_br)     nxt = ST_BEQ;
        else if (is_jp)     nxt = ST_JMP;
        else                nxt = ST_FETCH;
      end
      ST_ADDR:   nxt = is_ld ? ST_LDRD : (is_st ? ST_STWR : ST_FETCH);
      ST_LDRD:   nxt = ST_LDWB;
      ST_REXE:   nxt = ST_RWB;
      ST_LDWB, ST_STWR, ST_RWB, ST_BEQ, ST_JMP: nxt = ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcseq_state_reg.sv
module mcseq_state_reg
  import mcseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  mc_state_e nxt,
  output mc_state_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_FETCH;
    else     cur <= nxt;
  end

endmodule

// File: rtl/mcseq_out_decode.sv
module mcseq_out_decode
  import mcseq_pkg::*;
(
  input  mc_state_e cur,
  output mc_ctrl_t  ctl
);

  always_comb begin
    ctl           = '0;
    ctl.alu_a_sel = ASEL_PC;
    ctl.alu_b_sel = BSEL_REG;
    ctl.alu_op    = OP_ADD;
    ctl.pc_src    = SRC_ALU;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = BSEL_FOUR;
      end
      ST_DECODE: ctl.alu_b_sel = BSEL_SHFT;
      ST_ADDR: begin
        ctl.alu_a_sel = ASEL_REG;
        ctl.alu_b_sel = BSEL_SEXT;
      end
      ST_LDRD: ctl.mem_rd = 1'b1;
      ST_LDWB: begin
        ctl.rf_wr       = 1'b1;
        ctl.rf_from_mem = 1'b1;
      end
      ST_STWR: ctl.mem_wr = 1'b1;
      ST_REXE: begin
        ctl.alu_a_sel = ASEL_REG;
        ctl.alu_op    = OP_FUNCT;
      end
      ST_RWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.rf_dst = 1'b1;
      end
      ST_BEQ: begin
        ctl.br_wr     = 1'b1;
        ctl.alu_a_sel = ASEL_REG;
        ctl.alu_op    = OP_SUB;
        ctl.pc_src    = SRC_OUT;
      end
      ST_JMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = SRC_JUMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcseq_pc_gate.sv
module mcseq_pc_gate (
  input  logic pc_wr,
  input  logic br_wr,
  input  logic zero,
  output logic pc_load
);

  always_comb pc_load = pc_wr | (br_wr & zero);

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mcseq_pkg::*;
#(
  parameter int               OPC_W  = 6,
  parameter logic [OPC_W-1:0] OPC_R  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_LD = 6'h23,
  parameter logic [OPC_W-1:0] OPC_ST = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_BR = 6'h04,
  parameter logic [OPC_W-1:0] OPC_JP = 6'h02
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero,
  output logic             pc_wr,
  output logic             br_wr,
  output logic             ir_wr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             rf_wr,
  output logic             rf_dst,
  output logic             rf_from_mem,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_src,
  output logic             pc_load
);

  mc_state_e cur_st, nxt_st;
  mc_ctrl_t  ctl;

  mcseq_next_state #(
    .OPC_W(OPC_W), .OPC_R(OPC_R), .OPC_LD(OPC_LD),
    .OPC_ST(OPC_ST), .OPC_BR(OPC_BR), .OPC_JP(OPC_JP)
  ) u_next (
    .cur(cur_st), .opcode(opcode), .nxt(nxt_st)
  );

  mcseq_state_reg u_sreg (
    .clk(clk), .rst(rst), .nxt(nxt_st), .cur(cur_st)
  );

  mcseq_out_decode u_dec (
    .cur(cur_st), .ctl(ctl)
  );

  always_comb begin
    pc_wr       = ctl.pc_wr;
    br_wr       = ctl.br_wr;
    ir_wr       = ctl.ir_wr;
    mem_rd      = ctl.mem_rd;
    mem_wr      = ctl.mem_wr;
    rf_wr       = ctl.rf_wr;
    rf_dst      = ctl.rf_dst;
    rf_from_mem = ctl.rf_from_mem;
    alu_a_sel   = ctl.alu_a_sel;
    alu_b_sel   = ctl.alu_b_sel;
    alu_op      = ctl.alu_op;
    pc_src      = ctl.pc_src;
  end

  mcseq_pc_gate u_pcg (
    .pc_wr(ctl.pc_wr), .br_wr(ctl.br_wr), .zero(zero), .pc_load(pc_load)
  );

endmodule

// File: rtl/mc_ctrl_seq_chk.sv
module mc_ctrl_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pc_wr,
  input logic       br_wr,
  input logic       ir_wr,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       rf_wr,
  input logic       rf_dst,
  input logic       rf_from_mem,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_op,
  input logic [1:0] pc_src
);

  // R1: a reset edge yields the fetch controls
  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (ir_wr && pc_wr && mem_rd));

  // R3: fetch is always followed by decode
  a_r3_decode_next: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (!ir_wr && alu_b_sel == 2'b11 && !pc_wr && !rf_wr && !mem_wr));

  // R4: register-format write-back follows the function-field ALU cycle
  a_r4_rwb_after_exec: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && rf_dst) |-> $past(alu_op == 2'b10 && alu_a_sel));

  // R5: load write-back follows the memory read cycle
  a_r5_ldwb_after_read: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && rf_from_mem) |-> $past(mem_rd && !ir_wr));

  // R6: store write follows the address cycle
  a_r6_store_after_addr: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(alu_a_sel && alu_b_sel == 2'b10));

  // R7: branch cycle returns to fetch
  a_r7_branch_to_fetch: assert property (@(posedge clk) disable iff (rst)
    br_wr |=> ir_wr);

  // R8: jump cycle returns to fetch
  a_r8_jump_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_src == 2'b10) |=> ir_wr);

endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk u_chk (
  .clk(clk), .rst(rst), .pc_wr(pc_wr), .br_wr(br_wr), .ir_wr(ir_wr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_wr(rf_wr), .rf_dst(rf_dst),
  .rf_from_mem(rf_from_mem), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
  .alu_op(alu_op), .pc_src(pc_src)
);

// File: tb/mc_ctrl_seq_tb_top.sv
module mc_ctrl_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       zero = 1'b0;
  logic       pc_wr, br_wr, ir_wr, mem_rd, mem_wr, rf_wr, rf_dst, rf_from_mem;
  logic       alu_a_sel, pc_load;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mc_ctrl_seq dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
    .pc_wr(pc_wr), .br_wr(br_wr), .ir_wr(ir_wr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .rf_wr(rf_wr), .rf_dst(rf_dst), .rf_from_mem(rf_from_mem),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_src(pc_src), .pc_load(pc_load)
  );

  // Bit order: pc_wr br_wr ir_wr mem_rd mem_wr rf_wr rf_dst rf_from_mem a b[2] op[2] src[2]
  localparam logic [14:0] V_FETCH = 15'b1_0_1_1_0_0_0_0_0_01_00_00;
  localparam logic [14:0] V_DEC   = 15'b0_0_0_0_0_0_0_0_0_11_00_00;
  localparam logic [14:0] V_ADDR  = 15'b0_0_0_0_0_0_0_0_1_10_00_00;
  localparam logic [14:0] V_LDRD  = 15'b0_0_0_1_0_0_0_0_0_00_00_00;
  localparam logic [14:0] V_LDWB  = 15'b0_0_0_0_0_1_0_1_0_00_00_00;
  localparam logic [14:0] V_STWR  = 15'b0_0_0_0_1_0_0_0_0_00_00_00;
  localparam logic [14:0] V_REXE  = 15'b0_0_0_0_0_0_0_0_1_00_10_00;
  localparam logic [14:0] V_RWB   = 15'b0_0_0_0_0_1_1_0_0_00_00_00;
  localparam logic [14:0] V_BEQ   = 15'b0_1_0_0_0_0_0_0_1_00_01_01;
  localparam logic [14:0] V_JMP   = 15'b1_0_0_0_0_0_0_0_0_00_00_10;

  function automatic logic [14:0] got_vec();
    return {pc_wr, br_wr, ir_wr, mem_rd, mem_wr, rf_wr, rf_dst, rf_from_mem,
            alu_a_sel, alu_b_sel, alu_op, pc_src};
  endfunction

  // Sample now (falling edge), compare, then advance to next falling edge.
  task automatic step(input string tag, input logic [14:0] exp_v, input logic exp_pl);
    checks++;
    if (got_vec() !== exp_v) begin
      errors++;
      $display("FAIL %s ctrl got %b exp %b", tag, got_vec(), exp_v);
    end
    checks++;
    if (pc_load !== exp_pl) begin
      errors++;
      $display("FAIL R10 (%s) pc_load got %b exp %b", tag, pc_load, exp_pl);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    step("R1 held reset", V_FETCH, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_rformat();
    opcode = 6'h00;
    step("R2 fetch", V_FETCH, 1'b1);
    step("R3 decode", V_DEC, 1'b0);
    step("R4 exec", V_REXE, 1'b0);
    step("R4 writeback", V_RWB, 1'b0);
  endtask

  task automatic t_load();
    opcode = 6'h23;
    step("R2 fetch", V_FETCH, 1'b1);
    step("R3 decode", V_DEC, 1'b0);
    step("R5 address", V_ADDR, 1'b0);
    step("R5 read", V_LDRD, 1'b0);
    step("R5 writeback", V_LDWB, 1'b0);
  endtask

  task automatic t_store();
    opcode = 6'h2B;
    step("R2 fetch", V_FETCH, 1'b1);
    step("R3 decode", V_DEC, 1'b0);
    step("R6 address", V_ADDR, 1'b0);
    step("R6 write", V_STWR, 1'b0);
  endtask

  task automatic t_branch(input logic z);
    opcode = 6'h04;
    zero   = ~z;
    step("R2 fetch", V_FETCH, 1'b1);
    step("R3 decode", V_DEC, 1'b0);
    zero = z;
    #1;
    step(z ? "R7 compare taken" : "R7 compare not taken", V_BEQ, z);
    zero = 1'b0;
  endtask

  task automatic t_jump();
    opcode = 6'h02;
    step("R2 fetch", V_FETCH, 1'b1);
    step("R3 decode", V_DEC, 1'b0);
    step("R8 jump", V_JMP, 1'b1);
  endtask

  task automatic t_unknown(input logic [5:0] op);
    opcode = op;
    zero   = 1'b1;
    step("R2 fetch", V_FETCH, 1'b1);
    step("R9 decode no writes", V_DEC, 1'b0);
    zero = 1'b0;
  endtask

  task automatic t_mid_reset();
    opcode = 6'h23;
    step("R2 fetch", V_FETCH, 1'b1);
    step("R3 decode", V_DEC, 1'b0);
    step("R5 address", V_ADDR, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step("R1 reset abandons load", V_FETCH, 1'b1);
    step("R1 decode after reset", V_DEC, 1'b0);
    step("R5 address after reset", V_ADDR, 1'b0);
    step("R5 read after reset", V_LDRD, 1'b0);
    step("R5 wb after reset", V_LDWB, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_rformat();
    t_load();
    t_store();
    t_branch(1'b1);
    t_branch(1'b0);
    t_jump();
    t_unknown(6'h3F);
    t_unknown(6'h08);
    t_mid_reset();
    t_rformat();
    step("R4 return to fetch", V_FETCH, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got running exp finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule